// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable, small-depth model of a pipelined synchronous SRAM whose read and write latencies are equal, so that reads and writes can alternate on consecutive clock cycles without any idle bus cycle. A command is issued in one cycle. Its data moves on the data lines two enabled clock edges later. Write data arrives on `din` at that edge, and read data is presented on `dout` with a `dout_valid` flag from that edge onwards.

Each command either loads a new external address or advances an internal two-bit burst counter. The counter steps linearly through the four words of an aligned group and keeps the direction chosen when the burst was loaded. The three chip selects are only looked at when an address is loaded. Per-lane byte write enables are captured with each issued address and applied to the write data when it arrives later. The clock enable freezes every register. The sleep input masks all other inputs, ends any burst and drops any commands still in the pipeline, and it leaves the stored contents intact. The output enable acts asynchronously on the output only.

Top module: `zbt_sram`

## Requirements
- R1: A load cycle (`adv_ld_n`=0) with the device selected and `we_n`=1 issues a read of `addr`. Its word is shown on `dout` with `dout_valid`=1 after the second enabled clock edge that follows the issue edge.
- R2: A load with `we_n`=0 issues a write. The word on `din` at the second enabled edge after the issue edge is stored. Byte lane k (bits 8k+7..8k) is written only if `bw_n[k]` was 0 in the issue cycle.
- R3: The device is selected only when `ce1_n`=0, `ce2_n`=0 and `ce3`=1 at a load edge. A load without that selection issues nothing and ends any running burst. Chip selects are ignored on advance cycles.
- R4: With a burst running, `adv_ld_n`=1 issues the next address. The low two bits are incremented modulo 4 and the upper bits are unchanged.
- R5: `we_n` is ignored on advance cycles. Each beat keeps the direction set at load time.
- R6: Reads and writes may be issued on consecutive cycles in any mix with no idle cycle. A read issued right after a write to the same address returns the newly written bytes.
- R7: While `cke_n`=1, the clock edge has no effect. No write is performed, `dout` and `dout_valid` hold their values, and the burst does not advance.
- R8: While `sleep`=1, every other input is ignored. The running burst ends, commands still in flight are dropped without touching memory, `dout_valid` goes low, and the stored contents are kept.
- R9: When `oe_n`=1, `dout` reads as zero and `dout_valid` as 0, without delay. The pipeline is not affected.
- R10: After reset no burst is running and `dout_valid` is 0. An advance cycle issued before any load produces no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke_n | input | 1 | Clock enable, active low |
| sleep | input | 1 | Low-power hold; masks all other inputs |
| adv_ld_n | input | 1 | 0 = load external address, 1 = advance burst |
| we_n | input | 1 | Direction at load: 0 write, 1 read |
| ce1_n | input | 1 | Chip select, active low |
| ce2_n | input | 1 | Chip select, active low |
| ce3 | input | 1 | Chip select, active high |
| addr | input | ADDR_W | Word address |
| bw_n | input | LANES | Byte write enables, active low, one per lane |
| din | input | LANES*LANE_W | Write data, taken two enabled edges after issue |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dout | output | LANES*LANE_W | Read data |
| dout_valid | output | 1 | Read data on `dout` is valid |

## Verification
The whole array is first filled by single full-word writes. Then selected words are read back to confirm the plain load path. Masked writes show that only the chosen lanes change. Write bursts and read bursts that start mid-group separate linear wrap-around from plain incrementing. During these bursts, deliberately wrong values on `we_n`, the chip selects and `addr` show which inputs are really ignored. Interleaved write/read pairs to the same word show the zero-idle turnaround and that fresh data is returned.

Several patterns tell a stall, a sleep and an output-enable gap apart by what each does to data in flight:
- Stall cycles inserted in the middle of a write, a read, a burst and a visible result shift the due edge and hold the output.
- Sleep cycles inserted after a write or a read drop the operation, and the old contents stay.
- An output-enable gap hides a result without disturbing the next one.

// File: rtl/zbt_pkg.sv
// Shared definitions for the pipelined zero-turnaround SRAM model.
// Assumes: commands flow through the pipeline as (kind, address, lane mask).
package zbt_pkg;

    // Kind of access carried by one pipeline slot.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Linear burst order: next low-order word index, wrapping within four.
    function automatic logic [1:0] burst_step(input logic [1:0] cur);
        return cur + 2'd1;
    endfunction

endpackage

// File: rtl/zbt_issue.sv
// Command decode and burst address generator.
// Turns the per-cycle control pins into one issued access (or none).
// On a load it samples chip selects, address, direction and lane mask.
// On an advance it steps the low two address bits of the running burst.
// Assumes: en is the decoded clock enable; sleep has priority over it.
module zbt_issue
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              sleep,
    input  logic              adv_ld_n,
    input  logic              we_n,
    input  logic              sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  bw_n,
    output op_e               iss_kind,
    output logic [ADDR_W-1:0] iss_addr,
    output logic [LANES-1:0]  iss_bw_n
);
    localparam int HI_W = ADDR_W - 2;

    logic            act;
    logic            dir_wr;
    logic [HI_W-1:0] base_hi;
    logic [1:0]      cnt;

    // Decode the access issued at the coming edge.
    always_comb begin
        iss_kind = OP_IDLE;
        iss_addr = '0;
        iss_bw_n = bw_n;
        if (!sleep) begin
            if (!adv_ld_n) begin
                if (sel) begin
                    iss_kind = we_n ? OP_READ : OP_WRITE;
                    iss_addr = addr;
                end
            end else if (act) begin
                iss_kind = dir_wr ? OP_WRITE : OP_READ;
                iss_addr = {base_hi, burst_step(cnt)};
            end
        end
    end

    // Burst state: load on selected load cycles, step on advances.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act     <= 1'b0;
            dir_wr  <= 1'b0;
            base_hi <= '0;
            cnt     <= '0;
        end else if (sleep) begin
            act <= 1'b0;
        end else if (en) begin
            if (!adv_ld_n) begin
                act     <= sel;
                dir_wr  <= !we_n;
                base_hi <= addr[ADDR_W-1:2];
                cnt     <= addr[1:0];
            end else if (act) begin
                cnt <= burst_step(cnt);
            end
        end
    end

    // R4: an advance during a burst moves the counter by exactly one.
    a_r4_counter_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !sleep && adv_ld_n && act) |=> (cnt == $past(cnt) + 2'd1));

    // R5: the direction of a burst is frozen across advance cycles.
    a_r5_dir_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !sleep && adv_ld_n) |=> $stable(dir_wr));

    // R3: a load without full selection leaves no burst running.
    a_r3_deselect_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !sleep && !adv_ld_n && !sel) |=> !act);

    // R7: a disabled clock edge leaves the burst state untouched.
    a_r7_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !sleep) |=> ($stable(cnt) && $stable(act) && $stable(base_hi)));

    // R8: sleep terminates any running burst.
    a_r8_sleep_ends: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !act);

endmodule

// File: rtl/zbt_pipe.sv
// Two-slot command pipeline between issue and the data phase.
// Slot 1 holds the access issued at the last enabled edge; slot 2 the one
// before it, which meets its data at the next enabled edge.
// Assumes: sleep flushes both slots; a disabled edge holds them.
module zbt_pipe
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              sleep,
    input  op_e               in_kind,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [LANES-1:0]  in_bw_n,
    output op_e               out_kind,
    output logic [ADDR_W-1:0] out_addr,
    output logic [LANES-1:0]  out_bw_n
);
    op_e               s1_kind;
    logic [ADDR_W-1:0] s1_addr;
    logic [LANES-1:0]  s1_bw_n;

    // Shift both slots on an enabled edge; flush on reset or sleep.
    always_ff @(posedge clk) begin
        if (!rst_n || sleep) begin
            s1_kind  <= OP_IDLE;
            out_kind <= OP_IDLE;
        end else if (en) begin
            s1_kind  <= in_kind;
            out_kind <= s1_kind;
        end
    end

    // Address and lane mask follow their slot; no reset needed.
    always_ff @(posedge clk) begin
        if (en && !sleep) begin
            s1_addr  <= in_addr;
            s1_bw_n  <= in_bw_n;
            out_addr <= s1_addr;
            out_bw_n <= s1_bw_n;
        end
    end

    // R7: a disabled edge freezes both pipeline slots.
    a_r7_pipe_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !sleep) |=> ($stable(s1_kind) && $stable(out_kind)));

    // R8: sleep drops every access still in flight.
    a_r8_pipe_flush: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (s1_kind == OP_IDLE && out_kind == OP_IDLE));

    // R1: an issued access reaches the data slot after one more enabled edge.
    a_r1_slot_move: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !sleep && s1_kind != OP_IDLE) |=> (out_kind != OP_IDLE));

endmodule

// File: rtl/zbt_array.sv
// Storage array with per-lane write gating and a registered read port.
// Each byte lane has its own storage so a masked write touches only it.
// Assumes: the access presented here is in its data phase this edge.
module zbt_array
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    sleep,
    input  op_e                     kind,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        bw_n,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] rd_data,
    output logic                    rd_valid
);
    localparam int DEPTH = 1 << ADDR_W;

    logic live;
    assign live = en && !sleep;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] rq;

        // Write this lane when the data-phase write enables it.
        always_ff @(posedge clk) begin
            if (live && kind == OP_WRITE && !bw_n[g])
                mem[addr] <= din[g*LANE_W +: LANE_W];
        end

        // Capture this lane's read word in the data phase of a read.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rq <= '0;
            else if (live && kind == OP_READ)
                rq <= mem[addr];
        end

        assign rd_data[g*LANE_W +: LANE_W] = rq;
    end

    // Valid flag follows the data phase; sleep clears it, stall holds it.
    always_ff @(posedge clk) begin
        if (!rst_n || sleep)
            rd_valid <= 1'b0;
        else if (en)
            rd_valid <= (kind == OP_READ);
    end

    // R7: read output is frozen across a disabled edge.
    a_r7_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !sleep) |=> ($stable(rd_valid) && $stable(rd_data)));

    // R8: no valid read output while or after sleeping.
    a_r8_out_clear: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !rd_valid);

endmodule

// File: rtl/zbt_sram.sv
// Pipelined zero-turnaround synchronous SRAM, top level.
// Wires the command decoder, the two-slot pipeline and the array, and
// gates the read port with the asynchronous output enable.
// Assumes: separate data-in and data-out lines instead of a shared bus.
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cke_n,
    input  logic                    sleep,
    input  logic                    adv_ld_n,
    input  logic                    we_n,
    input  logic                    ce1_n,
    input  logic                    ce2_n,
    input  logic                    ce3,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        bw_n,
    input  logic [LANES*LANE_W-1:0] din,
    input  logic                    oe_n,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_valid
);
    localparam int DATA_W = LANES * LANE_W;

    logic              en;
    logic              sel;
    op_e               iss_kind;
    logic [ADDR_W-1:0] iss_addr;
    logic [LANES-1:0]  iss_bw_n;
    op_e               dp_kind;
    logic [ADDR_W-1:0] dp_addr;
    logic [LANES-1:0]  dp_bw_n;
    logic [DATA_W-1:0] rd_data;
    logic              rd_valid;

    // Decode clock enable and the three-way chip select.
    assign en  = !cke_n;
    assign sel = !ce1_n && !ce2_n && ce3;

    zbt_issue #(.ADDR_W(ADDR_W), .LANES(LANES)) u_issue (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .sleep    (sleep),
        .adv_ld_n (adv_ld_n),
        .we_n     (we_n),
        .sel      (sel),
        .addr     (addr),
        .bw_n     (bw_n),
        .iss_kind (iss_kind),
        .iss_addr (iss_addr),
        .iss_bw_n (iss_bw_n)
    );

    zbt_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .sleep    (sleep),
        .in_kind  (iss_kind),
        .in_addr  (iss_addr),
        .in_bw_n  (iss_bw_n),
        .out_kind (dp_kind),
        .out_addr (dp_addr),
        .out_bw_n (dp_bw_n)
    );

    zbt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .sleep    (sleep),
        .kind     (dp_kind),
        .addr     (dp_addr),
        .bw_n     (dp_bw_n),
        .din      (din),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    // Output enable gates the read port without touching any state.
    assign dout       = oe_n ? '0 : rd_data;
    assign dout_valid = rd_valid && !oe_n;

endmodule

// File: tb/zbt_sram_tb.sv
module zbt_sram_tb;
    localparam int CLK_P = 10;
    localparam int AW    = 6;
    localparam int LN    = 4;
    localparam int DW    = 32;

    logic          clk = 1'b0;
    logic          rst_n, cke_n, sleep, adv_ld_n, we_n, ce1_n, ce2_n, ce3, oe_n;
    logic [AW-1:0] addr;
    logic [LN-1:0] bw_n;
    logic [DW-1:0] din, dout;
    logic          dout_valid;

    always #(CLK_P/2) clk = ~clk;

    zbt_sram u_dut (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .sleep(sleep),
        .adv_ld_n(adv_ld_n), .we_n(we_n), .ce1_n(ce1_n), .ce2_n(ce2_n),
        .ce3(ce3), .addr(addr), .bw_n(bw_n), .din(din), .oe_n(oe_n),
        .dout(dout), .dout_valid(dout_valid)
    );

    typedef struct {
        int            due;
        logic [DW-1:0] d;
        bit            hid;
        string         tag;
    } exp_t;

    exp_t          q[$];
    logic [DW-1:0] model [int];
    logic [DW-1:0] din_at [int];
    int            n_chk = 0, n_bad = 0, ecnt = 0;
    bit            mon_on = 0;

    task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at edge %0d: actual %h expected %h", tag, ecnt, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw, logic [LN-1:0] m);
        logic [DW-1:0] r = old;
        for (int k = 0; k < LN; k++)
            if (!m[k]) r[k*8 +: 8] = nw[k*8 +: 8];
        return r;
    endfunction

    // Monitor: pops the scoreboard at each due edge, else expects no read.
    always @(posedge clk) begin
        exp_t e;
        #(CLK_P/4);
        if (mon_on) begin
            ecnt++;
            while (q.size() > 0 && q[0].due < ecnt) begin
                e = q.pop_front();
                chk(1'b0, {e.tag, " missed"}, '0, e.d);
            end
            if (q.size() > 0 && q[0].due == ecnt) begin
                e = q.pop_front();
                if (e.hid) begin
                    chk(dout_valid == 1'b0, {e.tag, " valid hidden"}, dout_valid, 0);
                    chk(dout == '0, {e.tag, " data hidden"}, dout, 0);
                end else begin
                    chk(dout_valid == 1'b1, {e.tag, " valid"}, dout_valid, 1);
                    chk(dout == e.d, {e.tag, " data"}, dout, e.d);
                end
            end else begin
                chk(dout_valid == 1'b0, "R3/R8 no read due", dout_valid, 0);
            end
        end
    end

    task automatic tick();
        din = din_at.exists(ecnt + 1) ? din_at[ecnt + 1] : (32'hD0D0_0000 | ecnt);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pins(bit ld, bit wr, bit c1n, bit c2n, bit c3, logic [AW-1:0] a);
        cke_n = 0; sleep = 0; adv_ld_n = !ld; we_n = !wr;
        ce1_n = c1n; ce2_n = c2n; ce3 = c3; addr = a; bw_n = '0;
    endtask

    task automatic idle();
        pins(1, 0, 0, 0, 0, '0);
        tick();
    endtask

    // Stall cycle: pins ask for a write advance that must be ignored.
    task automatic stall();
        pins(0, 1, 0, 0, 1, '0);
        cke_n = 1;
        tick();
    endtask

    // Sleep cycle: pins ask for a selected write load that must be ignored.
    task automatic snooze(logic [AW-1:0] a);
        pins(1, 1, 0, 0, 1, a);
        sleep = 1;
        tick();
    endtask

    // Driver: issue one beat and push its expectation (extra = stalls before due).
    task automatic issue(bit first, bit wr, logic [AW-1:0] a, logic [LN-1:0] bw,
                         logic [DW-1:0] d, int extra, string tag);
        int due = ecnt + 3 + extra;
        if (wr) begin
            din_at[due] = d;
            model[a] = merge(model.exists(a) ? model[a] : '0, d, bw);
        end else begin
            q.push_back('{due, model[a], 1'b0, tag});
        end
        if (first) pins(1, wr, 0, 0, 1, a);
        else       pins(0, !wr, 1, 1, 0, ~a);   // R5/R3: we_n, selects, addr ignored
        bw_n = bw;
        tick();
    endtask

    function automatic logic [AW-1:0] bad(logic [AW-1:0] base, int i);
        return {base[AW-1:2], 2'(base[1:0] + 2'(i))};
    endfunction

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 0; oe_n = 0;
        pins(1, 0, 0, 0, 0, '0);
        din = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        mon_on = 1;
        #1;
        chk(dout_valid == 1'b0, "R10 reset valid", dout_valid, 0);

        // R10: advance before any load issues nothing.
        pins(0, 0, 0, 0, 1, 6'd5); tick();
        pins(0, 1, 0, 0, 1, 6'd6); tick();
        idle(); idle();

        // R1/R2: fill the array with full-word writes, then read some back.
        for (int a = 0; a < 64; a++)
            issue(1, 1, 6'(a), 4'h0, 32'hA500_0000 ^ (32'(a) * 32'h0001_0203), 0, "R2 fill");
        idle(); idle();
        issue(1, 0, 6'd0,  4'hF, '0, 0, "R1 read 0");
        issue(1, 0, 6'd37, 4'hF, '0, 0, "R1 read 37");
        issue(1, 0, 6'd63, 4'hF, '0, 0, "R1 read 63");
        idle(); idle();

        // R2: masked write, lanes 0 and 2 only.
        issue(1, 1, 6'd4, 4'b1010, 32'hAABB_CCDD, 0, "R2 mask");
        idle(); idle();
        issue(1, 0, 6'd4, 4'hF, '0, 0, "R2 byte write readback");
        idle(); idle();

        // R4/R5: write burst from 8, read burst from 10 wrapping to 8.
        for (int i = 0; i < 4; i++)
            issue(i == 0, 1, bad(6'd8, i), 4'h0, 32'h5EED_0000 + 32'(i), 0, "R4 wburst");
        idle(); idle();
        for (int i = 0; i < 4; i++)
            issue(i == 0, 0, bad(6'd10, i), 4'hF, '0, 0, "R4 R5 rburst");
        idle(); idle();

        // R3: each chip select alone deselects; a deselect load ends a burst.
        pins(1, 0, 1, 0, 1, 6'd4); tick();
        pins(1, 0, 0, 1, 1, 6'd4); tick();
        pins(1, 0, 0, 0, 0, 6'd4); tick();
        issue(1, 0, 6'd12, 4'hF, '0, 0, "R3 before deselect");
        pins(1, 0, 1, 1, 0, 6'd12); tick();
        pins(0, 0, 0, 0, 1, 6'd12); tick();
        pins(0, 0, 0, 0, 1, 6'd12); tick();
        idle(); idle();

        // R6: write/read interleaved to the same words, no idle cycle.
        issue(1, 1, 6'd20, 4'h0, 32'h600D_0020, 0, "R6 w20");
        issue(1, 0, 6'd20, 4'hF, '0,            0, "R6 r20 after w20");
        issue(1, 1, 6'd21, 4'h0, 32'h600D_0021, 0, "R6 w21");
        issue(1, 0, 6'd21, 4'hF, '0,            0, "R6 r21 after w21");
        idle(); idle();

        // R7: stall inside a write, a read, a burst and on a shown result.
        issue(1, 1, 6'd30, 4'h0, 32'h57A1_1030, 1, "R7 write");
        stall(); idle(); idle(); idle();
        issue(1, 0, 6'd30, 4'hF, '0, 1, "R7 stalled read");
        stall(); idle(); idle(); idle();
        issue(1, 0, 6'd8, 4'hF, '0, 1, "R7 burst beat0");
        stall();
        issue(0, 0, 6'd9, 4'hF, '0, 0, "R7 burst beat1 no skip");
        idle(); idle(); idle();
        issue(1, 0, 6'd21, 4'hF, '0, 0, "R7 shown");
        q.push_back('{ecnt + 3, model[6'd21], 1'b0, "R7 held"});
        idle(); idle(); stall(); idle(); idle();

        // R8: sleep drops an in-flight write, keeps memory, ends a burst.
        pins(1, 1, 0, 0, 1, 6'd24); bw_n = '0;
        din_at[ecnt + 3] = 32'hBAD0_0024;
        tick();
        snooze(6'd24); idle(); idle();
        issue(1, 0, 6'd24, 4'hF, '0, 0, "R8 retained");
        idle(); idle();
        pins(1, 0, 0, 0, 1, 6'd8); tick();
        snooze(6'd8);
        pins(0, 0, 0, 0, 1, 6'd8); tick();
        idle(); idle();
        issue(1, 0, 6'd4, 4'hF, '0, 0, "R8 before sleep");
        idle(); idle(); snooze(6'd4); idle(); idle();

        // R9: output enable hides one result, the next one still appears.
        issue(1, 0, 6'd37, 4'hF, '0, 0, "R9 hidden");
        q[q.size() - 1].hid = 1'b1;
        issue(1, 0, 6'd20, 4'hF, '0, 0, "R9 after gap");
        oe_n = 1; idle();
        oe_n = 0; idle(); idle();

        chk(q.size() == 0, "R1 scoreboard drained", q.size(), 0);
        finish_run();
    end
endmodule